// File: doc/BRIEF.md
# Infrared Receiver Sampling Front End

This block turns a single infrared receiver line into bytes. The input passes through a two-flop synchronizer and an optional inverter. A counter, programmed with a 16-bit divisor, marks the end of each bit window. At that point one bit is sampled and shifted in, most significant bit first. Every eight bits form a byte, which is pushed into an eight-entry receive FIFO.

A small register bus gives access to the FIFO and its controls. Reading the data register pops the oldest byte. A status register reports the occupancy together with a data-ready flag and a data-lost flag; each flag is cleared by writing 1 to it, and writing 1 to a separate status bit empties the FIFO.

The line can be treated in one of two ways. It can be taken as already demodulated, so its level at the end of the window is the bit. It can also be taken as a raw carrier, so any active cycle inside the window makes the bit 1. One interrupt line reports pending data or loss when it is enabled.

Top module: `ir_sampler`

## Requirements
- R1: After reset the status register (address 2) reads 0x00, the interrupt is low, and the data register (address 0) reads 0x00. The divisor low (address 3) and high (address 4) registers read 0xA5 and 0x01. The control register (address 5) reads 0x02.
- R2: A write to address 3, 4 or 5 restarts the bit timing. A bit is then taken every divisor+1 clocks, the first bit taken goes to the most significant position, and a byte is pushed after 8 bits.
- R3: Control bit 0 set to 1 inverts the synchronized input before it is sampled.
- R4: Control bit 1 selects the line mode. When it is 1 the bit is the input level in the last cycle of the window. When it is 0 the bit is 1 if the input was active in any cycle of the window.
- R5: The FIFO holds 8 bytes and returns them oldest first. A read of address 0 pops one byte. A read while the FIFO is empty returns 0x00 and changes nothing.
- R6: Status bits [7:4] give the number of bytes held, from 0 to 8.
- R7: A byte that completes while the FIFO is full is discarded and status bit 1 (lost) is set. Writing 1 to bit 1 clears the flag.
- R8: Status bit 0 (ready) is set by every stored byte and cleared by writing 1 to bit 0. A store and a clear in the same cycle leave the flag set.
- R9: Writing 1 to status bit 3 empties the FIFO. The ready and lost flags are left unchanged, and bit 3 reads as 0.
- R10: The interrupt is high exactly when bit 7 of the enable register (address 1) is 1 and ready or lost is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_rx | input | 1 | Receiver line, asynchronous |
| we | input | 1 | Register write enable |
| rd | input | 1 | Read strobe; pops the FIFO when address is 0 |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same clock edge: a byte being stored, setting the ready flag, and a software write of 1 that clears that flag. The bench restarts the bit timing with a control write at a known edge, so the store edge is known to be 8×(divisor+1) clocks later. It places the clearing write on exactly that edge. After that edge the flag must still read 1, the interrupt must stay high and the byte must be in the FIFO; a second clear one cycle later must then take effect.

// File: rtl/ir_sampler.sv
module ir_sampler #(
  parameter int          DEPTH   = 8,
  parameter logic [15:0] DIV_RST = 16'h01A5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_rx,
  input  logic       we,
  input  logic       rd,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic        s1, s2;
  logic        inv, demod, en;
  logic [15:0] div;
  logic [15:0] tick;
  logic [2:0]  nbit;
  logic [7:0]  sh;
  logic        seen;
  logic [7:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] occ;
  logic        ready, lost;

  wire w_st    = we && addr == 3'd2;
  wire restart = we && (addr == 3'd3 || addr == 3'd4 || addr == 3'd5);
  wire lvl     = s2 ^ inv;
  wire tap     = tick == div;
  wire smp     = demod ? lvl : (seen | lvl);
  wire push    = tap && !restart && nbit == 3'd7;
  wire [7:0] pbyte = {sh[6:0], smp};
  wire flush   = w_st && wdata[3];
  wire pop     = rd && addr == 3'd0 && occ != '0;
  wire accept  = push && (occ != CW'(DEPTH) || pop);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= pin_rx;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div   <= DIV_RST;
      inv   <= 1'b0;
      demod <= 1'b1;
      en    <= 1'b0;
    end else if (we) begin
      case (addr)
        3'd1: en         <= wdata[7];
        3'd3: div[7:0]   <= wdata;
        3'd4: div[15:8]  <= wdata;
        3'd5: {demod, inv} <= wdata[1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tick <= '0;
      nbit <= '0;
      sh   <= '0;
      seen <= 1'b0;
    end else if (restart) begin
      tick <= '0;
      nbit <= '0;
      seen <= 1'b0;
    end else if (tap) begin
      tick <= '0;
      nbit <= nbit + 3'd1;
      sh   <= pbyte;
      seen <= 1'b0;
    end else begin
      tick <= tick + 16'd1;
      seen <= seen | lvl;
    end

  always_ff @(posedge clk)
    if (accept && !flush) mem[wp] <= pbyte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (accept) wp <= wp + PW'(1);
      if (pop)    rp <= rp + PW'(1);
      occ <= occ + CW'(accept) - CW'(pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ready <= 1'b0;
      lost  <= 1'b0;
    end else begin
      if (accept && !flush)            ready <= 1'b1;
      else if (w_st && wdata[0])       ready <= 1'b0;
      if (push && !accept && !flush)   lost  <= 1'b1;
      else if (w_st && wdata[1])       lost  <= 1'b0;
    end

  always_comb
    case (addr)
      3'd0:    rdata = (occ != '0) ? mem[rp] : 8'h00;
      3'd1:    rdata = {en, 7'b0};
      3'd2:    rdata = {4'(occ), 2'b00, lost, ready};
      3'd3:    rdata = div[7:0];
      3'd4:    rdata = div[15:8];
      3'd5:    rdata = {6'b0, demod, inv};
      default: rdata = 8'h00;
    endcase

  assign irq = en && (ready || lost);
endmodule

// File: rtl/ir_sampler_chk.sv
module ir_sampler_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] occ,
  input logic          push,
  input logic          pop,
  input logic          flush,
  input logic          ready,
  input logic          lost,
  input logic          en,
  input logic          irq
);
  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH)); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ == '0); // R9
  AST_LOST_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && occ == CW'(DEPTH) && !pop && !flush) |=> lost); // R7
  AST_READY_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (push && occ != CW'(DEPTH) && !flush) |=> ready); // R8
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush) |=> occ == $past(occ) - CW'(1)); // R5
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en && (ready || lost))); // R10
endmodule

bind ir_sampler ir_sampler_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .occ(occ), .push(push), .pop(pop),
  .flush(flush), .ready(ready), .lost(lost), .en(en), .irq(irq)
);

// File: tb/sim_ir_sampler.sv
module sim_ir_sampler;
  logic clk = 1'b0, rst_n = 1'b0, pin_rx = 1'b0, we = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  ir_sampler u0 (.clk(clk), .rst_n(rst_n), .pin_rx(pin_rx), .we(we), .rd(rd),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  // div, inv, demod, pulse, pattern, expected
  localparam logic [26:0] VEC [6] = '{
    {8'd3, 1'b0, 1'b1, 1'b0, 8'hA5, 8'hA5},
    {8'd5, 1'b0, 1'b1, 1'b0, 8'h3C, 8'h3C},
    {8'd3, 1'b1, 1'b1, 1'b0, 8'h0F, 8'hF0},
    {8'd4, 1'b0, 1'b0, 1'b1, 8'h96, 8'h96},
    {8'd4, 1'b0, 1'b1, 1'b1, 8'h96, 8'h00},
    {8'd6, 1'b1, 1'b0, 1'b0, 8'h81, 8'h7E}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic pop(output logic [7:0] v);
    addr = 3'd0; rd = 1'b1; #1; v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic stream(input int p, input logic [7:0] ctrl, input logic pulse,
                        input logic [79:0] bytes, input int n, input int clr_at);
    for (int i = 0; i < n * 8 * p + 4; i++) begin
      logic b;
      if (i < n * 8 * p) begin
        b = bytes[(i / (8 * p)) * 8 + 7 - ((i % (8 * p)) / p)];
        pin_rx = pulse ? (b && (i % p) == 0) : b;
      end else pin_rx = 1'b0;
      if (i == 1) begin we = 1'b1; addr = 3'd5; wdata = ctrl; end
      else if (i == clr_at) begin we = 1'b1; addr = 3'd2; wdata = 8'h01; end
      else we = 1'b0;
      @(negedge clk);
    end
    we = 1'b0;
    wr(3'd3, 8'hFF);
    wr(3'd4, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [79:0] bb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(3'd2, v); chk("R1 status", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    peek(3'd3, v); chk("R1 div low", v, 8'hA5);
    peek(3'd4, v); chk("R1 div high", v, 8'h01);
    peek(3'd5, v); chk("R1 ctrl", v, 8'h02);
    peek(3'd0, v); chk("R1 data", v, 8'h00);

    // R2 R3 R4 vector table
    foreach (VEC[k]) begin
      logic [26:0] t;
      t = VEC[k];
      wr(3'd3, t[26:19]);
      wr(3'd4, 8'h00);
      stream(int'(t[26:19]) + 1, {6'b0, t[17], t[18]}, t[16],
             {72'b0, t[15:8]}, 1, -1);
      peek(3'd2, v); chk("R6 occupancy one", v, 8'h11);
      pop(v); chk("R2 R3 R4 byte", v, t[7:0]);
      wr(3'd2, 8'h01);
    end

    // R5 R6 R7: nine bytes into an eight-entry FIFO
    for (int k = 0; k < 10; k++) bb[k*8 +: 8] = 8'h10 + 8'(k);
    wr(3'd3, 8'd2); wr(3'd4, 8'd0);
    stream(3, 8'h02, 1'b0, bb, 9, -1);
    peek(3'd2, v); chk("R6 R7 full and lost", v, 8'h83);
    chk("R10 irq masked", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h80);
    chk("R10 irq enabled", {7'b0, irq}, 8'h01);
    for (int k = 0; k < 8; k++) begin
      pop(v); chk("R5 order", v, 8'h10 + 8'(k));
    end
    pop(v); chk("R5 empty read", v, 8'h00);
    peek(3'd2, v); chk("R5 empty unchanged", v, 8'h03);
    wr(3'd2, 8'h01);
    peek(3'd2, v); chk("R8 ready cleared", v, 8'h02);
    chk("R10 irq from lost", {7'b0, irq}, 8'h01);
    wr(3'd2, 8'h02);
    peek(3'd2, v); chk("R7 lost cleared", v, 8'h00);
    chk("R10 irq idle", {7'b0, irq}, 8'h00);

    // R9 flush
    wr(3'd3, 8'd2); wr(3'd4, 8'd0);
    stream(3, 8'h02, 1'b0, bb, 3, -1);
    peek(3'd2, v); chk("R6 three held", v, 8'h31);
    wr(3'd2, 8'h08);
    peek(3'd2, v); chk("R9 flushed", v, 8'h01);
    pop(v); chk("R9 data after flush", v, 8'h00);
    wr(3'd2, 8'h01);

    // R8 store and clear on the same edge
    wr(3'd3, 8'd2); wr(3'd4, 8'd0);
    stream(3, 8'h02, 1'b0, {72'b0, 8'h5A}, 1, 8 * 3 + 1);
    peek(3'd2, v); chk("R8 set wins", v, 8'h11);
    chk("R10 irq kept", {7'b0, irq}, 8'h01);
    wr(3'd2, 8'h01);
    peek(3'd2, v); chk("R8 later clear", v, 8'h10);
    pop(v); chk("R8 byte stored", v, 8'h5A);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule